// File: doc/BRIEF.md
# Cascadable serial configuration memory

A bit-serial memory that feeds a configuration image to a loading device, one bit per clock. While it is selected and out of programming mode, it clocks its stored bits out in address order. With its own last bit it pulls its cascade output low. That output drives the chip select of the next memory in a chain, so the next memory takes over the stream on the following clock, with no idle cycle and no overlap.

A reset/output-enable input clears the address counter and the cascade state. Its active level is held in a polarity bit that can be rewritten while the memory is in programming mode. Contents are loaded through a synchronous one-bit write port, and that port only takes effect while serial enable is low. The three-state data pin is modelled as a data value plus an output-enable flag.

Top module: `sercfg_mem`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `data_oe` is 0 and `casc_n` is 1. The polarity bit returns to `POL_DEFAULT` (0 means the reset input is active-low, 1 means active-high).
- R2: When `ser_en`=1, `cs_n`=0, the reset input is inactive and the end of data has not been reached, each rising clock presents the bit at the current address on `data_o` with `data_oe`=1. The address then advances by one. After a clear, the stream starts at address 0.
- R3: The clock that presents the bit at address `LAST_ADDR` also drives `casc_n` low. From the next clock on, `data_oe` stays 0 until a clear.
- R4: In a chain, where `casc_n` of one instance drives `cs_n` of the next, the stream seen on the two outputs is the first memory's bits 0..LAST_ADDR followed at once by the second memory's bits. There is no cycle without a driver between them, and never a cycle in which both drive.
- R5: With `cs_n`=1 the memory is in standby. On the next clock `data_oe` is 0, whatever level the reset input has. The address holds, and a later select resumes at the next unsent bit.
- R6: A clock edge that sees the reset input at its active level clears the address to 0, returns `casc_n` to 1 and sets `data_oe` to 0.
- R7: A write with `pol_wr_en`=1 while `ser_en`=0 loads `pol_bit` into the polarity bit. The written level then acts as the clear level, and the opposite level allows streaming.
- R8: With `ser_en`=0 the memory is in programming mode. `data_oe` is 0 on the next clock and the address holds.
- R9: A write with `wr_en`=1 stores `wr_bit` at `wr_addr` only while `ser_en`=0. A write while `ser_en`=1 leaves the contents unchanged.
- R10: When `LAST_ADDR` is less than DEPTH-1, bits above `LAST_ADDR` are never sent, and the cascade handover follows address `LAST_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | 1 = read mode, 0 = programming mode |
| cs_n | input | 1 | Active-low chip select |
| rstoe | input | 1 | Reset/output-enable input; active level set by the polarity bit |
| wr_en | input | 1 | Load-port write strobe |
| wr_addr | input | AW | Load-port bit address |
| wr_bit | input | 1 | Load-port data bit |
| pol_wr_en | input | 1 | Polarity bit write strobe |
| pol_bit | input | 1 | New polarity (1 = active-high) |
| data_o | output | 1 | Serial data value |
| data_oe | output | 1 | Serial data drive enable |
| casc_n | output | 1 | Active-low cascade output to the next chip select |

## Verification
The bench chains two instances. The first has DEPTH=32 and LAST_ADDR=19, so its contents are only partly used: junk ones sit above the last valid address, and any overshoot would show up in the stream. The second has DEPTH=16 and LAST_ADDR=15, so it is completely full. These sizes put the handover edge, the standby and programming pauses in the middle of a stream, and the polarity switch all within a few hundred cycles.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  typedef enum logic [2:0] {
    SC_CLEAR,
    SC_PROG,
    SC_IDLE,
    SC_DONE,
    SC_RUN
  } sc_mode_e;
endpackage

// File: rtl/sercfg_ctrl.sv
module sercfg_ctrl
  import sercfg_pkg::*;
#(
  parameter logic POL_DEFAULT = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ser_en,
  input  logic     cs_n,
  input  logic     rstoe,
  input  logic     pol_wr_en,
  input  logic     pol_bit,
  input  logic     done,
  output logic     pol_q,
  output sc_mode_e mode
);
  // polarity bit: 1 means the reset input clears when high
  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= POL_DEFAULT;
    end else if (!ser_en && pol_wr_en) begin
      pol_q <= pol_bit;
    end
  end

  // priority: clear, programming, standby, exhausted, streaming
  always_comb begin
    if (rstoe == pol_q)  mode = SC_CLEAR;
    else if (!ser_en)    mode = SC_PROG;
    else if (cs_n)       mode = SC_IDLE;
    else if (done)       mode = SC_DONE;
    else                 mode = SC_RUN;
  end
endmodule

// File: rtl/sercfg_addr_ctr.sv
module sercfg_addr_ctr
  import sercfg_pkg::*;
#(
  parameter int AW        = 6,
  parameter int LAST_ADDR = 63
) (
  input  logic          clk,
  input  logic          rst,
  input  sc_mode_e      mode,
  output logic [AW-1:0] addr_q,
  output logic          done_q
);
  localparam logic [AW-1:0] LAST_A = AW'(LAST_ADDR);

  logic at_last;
  assign at_last = (addr_q == LAST_A);

  always_ff @(posedge clk) begin
    if (rst || mode == SC_CLEAR) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (mode == SC_RUN) begin
      if (at_last) done_q <= 1'b1;
      else         addr_q <= addr_q + AW'(1);
    end
  end
endmodule

// File: rtl/sercfg_bitstore.sv
module sercfg_bitstore #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
  end

  // registered read port, RAM-inferable
  always_ff @(posedge clk) begin
    if (re) rbit <= mem[raddr];
  end
endmodule

// File: rtl/sercfg_mem.sv
module sercfg_mem
  import sercfg_pkg::*;
#(
  parameter int   DEPTH       = 64,
  parameter int   LAST_ADDR   = DEPTH - 1,
  parameter logic POL_DEFAULT = 1'b0,
  localparam int  AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_en,
  input  logic          cs_n,
  input  logic          rstoe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic          pol_wr_en,
  input  logic          pol_bit,
  output logic          data_o,
  output logic          data_oe,
  output logic          casc_n
);
  sc_mode_e      mode;
  logic          pol_q;
  logic [AW-1:0] addr_q;
  logic          done_q;
  logic          rbit;
  logic          oe_q;

  sercfg_ctrl #(.POL_DEFAULT(POL_DEFAULT)) u_ctrl (
    .clk(clk), .rst(rst), .ser_en(ser_en), .cs_n(cs_n), .rstoe(rstoe),
    .pol_wr_en(pol_wr_en), .pol_bit(pol_bit), .done(done_q),
    .pol_q(pol_q), .mode(mode)
  );

  sercfg_addr_ctr #(.AW(AW), .LAST_ADDR(LAST_ADDR)) u_ctr (
    .clk(clk), .rst(rst), .mode(mode), .addr_q(addr_q), .done_q(done_q)
  );

  sercfg_bitstore #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(wr_en && mode == SC_PROG), .waddr(wr_addr), .wbit(wr_bit),
    .re(mode == SC_RUN), .raddr(addr_q), .rbit(rbit)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= (mode == SC_RUN);
  end

  assign data_oe = oe_q;
  assign data_o  = rbit & oe_q;
  assign casc_n  = ~done_q;
endmodule

// File: rtl/sercfg_mem_chk.sv
module sercfg_mem_chk #(
  parameter int AW        = 6,
  parameter int LAST_ADDR = 63
) (
  input logic          clk,
  input logic          rst,
  input logic          ser_en,
  input logic          cs_n,
  input logic          rstoe,
  input logic          pol_q,
  input logic [AW-1:0] addr_q,
  input logic          data_oe,
  input logic          casc_n
);
  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ser_en && !cs_n && rstoe != pol_q && casc_n && addr_q != AW'(LAST_ADDR))
      |=> addr_q == $past(addr_q) + AW'(1));

  p_casc_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(casc_n) |-> data_oe);

  p_casc_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!casc_n && $past(!casc_n)) |-> !data_oe);

  p_oe_needs_sel_r5: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(!cs_n && ser_en));

  p_standby_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cs_n && rstoe != pol_q) |=> $stable(addr_q));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rstoe == pol_q) |-> (casc_n && !data_oe));

  p_prog_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!ser_en) |-> !data_oe);
endmodule

bind sercfg_mem sercfg_mem_chk #(.AW(AW), .LAST_ADDR(LAST_ADDR)) u_chk (
  .clk(clk), .rst(rst), .ser_en(ser_en), .cs_n(cs_n), .rstoe(rstoe),
  .pol_q(pol_q), .addr_q(addr_q), .data_oe(data_oe), .casc_n(casc_n)
);

// File: tb/tb_sercfg_mem.sv
module tb_sercfg_mem;
  localparam int CLK_PERIOD = 10;
  localparam int LAST_A = 19;
  localparam int LAST_B = 15;

  typedef struct {bit val; bit src; int idx;} exp_t;
  exp_t sb_q[$];

  logic clk = 1'b0;
  logic rst, ser_en, cs_a, rstoe, wr_en_a, wr_en_b, wr_bit, pol_wr_en, pol_bit;
  logic [4:0] wr_addr;
  logic d_a, oe_a, casc_a, d_b, oe_b, casc_b;
  bit mon_on = 1'b0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sercfg_mem #(.DEPTH(32), .LAST_ADDR(LAST_A)) dut (
    .clk(clk), .rst(rst), .ser_en(ser_en), .cs_n(cs_a), .rstoe(rstoe),
    .wr_en(wr_en_a), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .pol_wr_en(pol_wr_en), .pol_bit(pol_bit),
    .data_o(d_a), .data_oe(oe_a), .casc_n(casc_a)
  );

  sercfg_mem #(.DEPTH(16), .LAST_ADDR(LAST_B)) dut_nxt (
    .clk(clk), .rst(rst), .ser_en(ser_en), .cs_n(casc_a), .rstoe(rstoe),
    .wr_en(wr_en_b), .wr_addr(wr_addr[3:0]), .wr_bit(wr_bit),
    .pol_wr_en(pol_wr_en), .pol_bit(pol_bit),
    .data_o(d_b), .data_oe(oe_b), .casc_n(casc_b)
  );

  function automatic bit pat_a(int i);
    return bit'(((i * 5 + 1) ^ (i >> 2)) & 1);
  endfunction

  function automatic bit pat_b(int i);
    return bit'(((i * 3) ^ (i >> 1) ^ 1) & 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // driver side of the scoreboard: whole chain stream in order
  task automatic push_chain();
    for (int i = 0; i <= LAST_A; i++) sb_q.push_back('{pat_a(i), 1'b0, i});
    for (int i = 0; i <= LAST_B; i++) sb_q.push_back('{pat_b(i), 1'b1, i});
  endtask

  task automatic end_checks();
    chk(sb_q.size() == 0, "R4 R10 stream length", sb_q.size(), 0);
    chk(!oe_a && !oe_b, "R3 drivers off after end", int'(oe_a) + int'(oe_b), 0);
    chk(casc_a == 1'b0, "R3 first cascade low", casc_a, 0);
    chk(casc_b == 1'b0, "R3 second cascade low", casc_b, 0);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (oe_a && oe_b) begin
        chk(1'b0, "R4 overlap", 2, 1);
      end else if (oe_a || oe_b) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R4 R10 extra bit", 1, 0);
        end else begin
          exp_t e;
          bit got;
          string req;
          e = sb_q.pop_front();
          got = oe_a ? d_a : d_b;
          req = (e.src == 1'b0 && e.idx == 0) ? "R2 R9 data" :
                (e.src == 1'b1 && e.idx == 0) ? "R4 R10 handover data" : "R2 data";
          chk(got == e.val, req, got, e.val);
          chk(oe_b == e.src, "R4 driving instance", oe_b, e.src);
          if (e.src == 1'b0)
            chk(casc_a == (e.idx != LAST_A), "R3 cascade timing", casc_a, int'(e.idx != LAST_A));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; ser_en = 0; cs_a = 1; rstoe = 1; wr_en_a = 0; wr_en_b = 0;
    wr_addr = '0; wr_bit = 0; pol_wr_en = 0; pol_bit = 0;
    repeat (3) tick();
    chk(!oe_a && !oe_b, "R1 oe in reset", int'(oe_a) + int'(oe_b), 0);
    rst = 0;
    tick();
    chk(!oe_a && !oe_b, "R1 oe after reset", int'(oe_a) + int'(oe_b), 0);
    chk(casc_a && casc_b, "R1 cascade after reset", int'(casc_a) + int'(casc_b), 2);

    // load contents; junk ones above the last valid address (R10)
    for (int i = 0; i < 32; i++) begin
      wr_addr = 5'(i); wr_bit = (i <= LAST_A) ? pat_a(i) : 1'b1; wr_en_a = 1; tick();
    end
    wr_en_a = 0;
    for (int i = 0; i <= LAST_B; i++) begin
      wr_addr = 5'(i); wr_bit = pat_b(i); wr_en_b = 1; tick();
    end
    wr_en_b = 0;

    // R8: selected but in programming mode
    cs_a = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(!oe_a, "R8 no stream in programming mode", oe_a, 0);
    end

    // run 1: full chain
    push_chain();
    mon_on = 1;
    ser_en = 1;
    repeat (40) tick();
    end_checks();

    // R9: write attempt in read mode must not land
    wr_addr = '0; wr_bit = ~pat_a(0); wr_en_a = 1; tick(); wr_en_a = 0;

    // R6: active-low clear, then run 2 with a standby pause (R5)
    push_chain();
    rstoe = 0;
    tick();
    chk(casc_a == 1'b1, "R6 cascade released", casc_a, 1);
    chk(!oe_a, "R6 output off on clear", oe_a, 0);
    rstoe = 1;
    repeat (5) tick();
    cs_a = 1;
    rstoe = 0; // R5: standby output off whatever the reset input does
    tick();
    chk(!oe_a, "R5 standby output off", oe_a, 0);
    rstoe = 1;
    repeat (2) begin
      tick();
      chk(!oe_a, "R5 standby holds off", oe_a, 0);
    end
    chk(sb_q.size() == 1 + LAST_A + LAST_B + 1 - 5, "R5 bits sent before pause",
        sb_q.size(), LAST_A + LAST_B + 2 - 5);
    sb_q.delete();
    push_chain();
    // the pause in run 2 cleared via rstoe=0: stream restarts at bit 0 (R6)
    cs_a = 0;
    repeat (40) tick();
    end_checks();

    // R7: switch to active-high; level 1 clears, level 0 streams
    ser_en = 0; pol_bit = 1; pol_wr_en = 1;
    tick();
    pol_wr_en = 0;
    tick();
    chk(casc_a == 1'b1, "R7 active-high clear first", casc_a, 1);
    chk(casc_b == 1'b1, "R7 active-high clear second", casc_b, 1);
    rstoe = 0;
    push_chain();
    ser_en = 1;
    repeat (8) tick();
    ser_en = 0;
    tick();
    chk(!oe_a, "R8 pause mid-stream", oe_a, 0);
    tick();
    chk(!oe_a, "R8 pause holds", oe_a, 0);
    ser_en = 1;
    repeat (40) tick();
    end_checks();

    mon_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule